// File: doc/BRIEF.md
# Serial Register Port with Deferred Update

This block is a synchronous serial slave that lets a host reach a small bank of byte-wide registers. A host lowers the chip select, clocks in an instruction byte that names a register and says whether it reads or writes, then clocks one data byte. Written bytes land in a shadow buffer. A separate update input, once it has passed a synchroniser and a minimum-width check, copies the whole shadow buffer into the active registers in one clock. The active registers drive the block's parallel output.

All serial inputs pass through two-stage synchronisers into the system clock domain. Serial clock edges are found there: input bits are taken on rising edges and read bits are launched on falling edges, so the host may leave the serial clock idling either low or high between bursts. Register 0 holds two mode bits. Bit 0 selects LSB-first order for every byte on the wire, instruction byte included. Bit 1 selects the 3-wire read path, which uses a dedicated output, in place of the 2-wire path, which turns the shared data line around. Both bits act only once an update has moved them into the active copy.

The controller is a five-state machine. ST_IDLE waits for chip select and goes to ST_INSTR. ST_INSTR collects eight bits and then goes to ST_RDATA when the read flag is set, or to ST_WDATA when it is clear. ST_WDATA collects eight bits, writes the shadow buffer and goes to ST_DONE. ST_RDATA shifts out the active value and holds until chip select goes high. ST_DONE ignores the bus until chip select goes high. When chip select goes high, every state returns to ST_IDLE.

Top module: `serreg_port`

## Requirements
- R1: A transaction is one instruction byte followed by one data byte. In the instruction byte, taken in canonical order with bit 7 as the most significant, bit 7 is the read flag (1 = read, 0 = write), bits 4..0 are the register address and bits 6..5 are ignored.
- R2: A write changes only the shadow buffer. `regs_o` stays unchanged until a qualified update occurs.
- R3: An update is qualified when the synchronised update input is high on two consecutive system clocks. One qualified update copies every shadow register into the active registers once. A pulse that is seen high for only one clock has no effect.
- R4: Register 0 bit 0 selects bit order: 0 is MSB first, 1 is LSB first. Register 0 resets to 0. A new value written there changes the bit order only after an update.
- R5: In LSB-first order, the instruction byte, the write data and the read data all travel least significant bit first. In MSB-first order they all travel most significant bit first.
- R6: A read returns the active value, not a pending shadow value. Register `k` occupies `regs_o[8k+7:8k]`. An address at or above NREGS reads as 0, and a write to such an address changes nothing.
- R7: Register 0 bit 1 selects the read path. With the bit at 1 (3-wire), read bits appear on `sdo` and `sdio_oe` stays 0. With the bit at 0 (2-wire), read bits appear on `sdio_o` and `sdio_oe` is 1 throughout the read data phase.
- R8: Input bits are taken on rising serial clock edges. Each read bit is launched on a falling edge. Reads and writes work with the serial clock idling low and with it idling high.
- R9: Raising `cs_n` aborts any partial byte, including a write whose data byte is unfinished. The next transaction starts with a fresh instruction byte.
- R10: While reset is held, `regs_o`, `sdio_oe`, `sdio_o` and `sdo` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host |
| sdio_i | input | 1 | Serial data line, input side |
| sdio_o | output | 1 | Serial data line, output side (2-wire reads) |
| sdio_oe | output | 1 | Output enable for the shared data line |
| sdo | output | 1 | Dedicated read output (3-wire reads) |
| io_update | input | 1 | Update request; copies shadow to active once qualified |
| regs_o | output | NREGS*8 | Active register contents, register k at bits 8k+7..8k |

## Verification
Serial edges reach the state machine about three system clocks after the host moves `sclk`: two synchroniser stages and one edge register. The bench therefore holds every serial clock phase for eight system clocks and reads a read bit just before it raises the following rising edge. A qualified update changes `regs_o` about four clocks after `io_update` rises. The bench waits ten clocks after each update pulse before it compares the outputs. A write reaches the shadow buffer within a few clocks of the last rising edge, and the bench confirms through `regs_o` that nothing moves before the update. The sweep covers both idle levels, both bit orders and both read paths, with expected values derived from an arithmetic pattern.

// File: rtl/serreg_pkg.sv
package serreg_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INSTR,
        ST_WDATA,
        ST_RDATA,
        ST_DONE
    } serreg_state_t;

    function automatic logic [BYTE_W-1:0] flip_byte(input logic [BYTE_W-1:0] v);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) begin
            r[i] = v[BYTE_W-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/serreg_sync.sv
module serreg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    input  logic [W-1:0] rst_val,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage[s] <= rst_val;
                    else        stage[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage[s] <= rst_val;
                    else        stage[s] <= stage[s-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/serreg_upd_qual.sv
module serreg_upd_qual #(
    parameter int MIN_HIGH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic upd_s,
    output logic fire
);
    localparam int CW = $clog2(MIN_HIGH + 1);

    logic [CW-1:0] high_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            high_cnt <= '0;
        end else if (!upd_s) begin
            high_cnt <= '0;
        end else if (high_cnt != CW'(MIN_HIGH)) begin
            high_cnt <= high_cnt + 1'b1;
        end
    end

    assign fire = upd_s && (high_cnt == CW'(MIN_HIGH - 1));

    // R3: a copy is only triggered after the update has been seen high before
    assert_qual_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (upd_s && $past(upd_s)));
endmodule

// File: rtl/serreg_bank.sv
module serreg_bank #(
    parameter int NREGS = 4,
    parameter int AW    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [7:0]           wr_data,
    input  logic                 upd_fire,
    input  logic [AW-1:0]        rd_addr,
    output logic [7:0]           rd_data,
    output logic [NREGS*8-1:0]   active_flat
);
    localparam int IW = (NREGS > 1) ? $clog2(NREGS) : 1;

    logic [NREGS*8-1:0] shadow_flat;

    generate
        for (genvar g = 0; g < NREGS; g++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    shadow_flat[g*8 +: 8] <= '0;
                end else if (wr_en && (wr_addr == AW'(g))) begin
                    shadow_flat[g*8 +: 8] <= wr_data;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    active_flat[g*8 +: 8] <= '0;
                end else if (upd_fire) begin
                    active_flat[g*8 +: 8] <= shadow_flat[g*8 +: 8];
                end
            end
        end
    endgenerate

    logic in_range;
    logic [IW-1:0] rd_idx;

    assign in_range = ({1'b0, rd_addr} < (AW+1)'(NREGS));
    assign rd_idx   = rd_addr[IW-1:0];
    assign rd_data  = in_range ? active_flat[rd_idx*8 +: 8] : 8'h00;

    // R2: active registers never move without a qualified update
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_fire |=> $stable(active_flat));
    // R3: an update copies the shadow contents of the preceding cycle
    assert_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_fire |=> (active_flat == $past(shadow_flat)));
endmodule

// File: rtl/serreg_fsm.sv
module serreg_fsm
    import serreg_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_act,
    input  logic          sclk_s,
    input  logic          sdi_s,
    input  logic          lsb_first,
    input  logic          three_wire,
    input  logic [7:0]    rd_data,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic [AW-1:0] rd_addr,
    output logic          sdio_o,
    output logic          sdio_oe,
    output logic          sdo
);
    serreg_state_t state, nxt;

    logic          sclk_q;
    logic          rise, fall;
    logic [2:0]    bit_cnt;
    logic [7:0]    rx_sh;
    logic [7:0]    tx_sh;
    logic [AW-1:0] addr_q;
    logic          out_bit;
    logic [7:0]    rx_next;
    logic [7:0]    rx_canon;
    logic          byte_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end

    assign rise      = sclk_s && !sclk_q;
    assign fall      = !sclk_s && sclk_q;
    assign rx_next   = {rx_sh[6:0], sdi_s};
    assign rx_canon  = lsb_first ? flip_byte(rx_next) : rx_next;
    assign byte_done = rise && (bit_cnt == 3'd7);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (cs_act) nxt = ST_INSTR;
            end
            ST_INSTR: begin
                if (!cs_act)        nxt = ST_IDLE;
                else if (byte_done) nxt = rx_canon[7] ? ST_RDATA : ST_WDATA;
            end
            ST_WDATA: begin
                if (!cs_act)        nxt = ST_IDLE;
                else if (byte_done) nxt = ST_DONE;
            end
            ST_RDATA: begin
                if (!cs_act) nxt = ST_IDLE;
            end
            ST_DONE: begin
                if (!cs_act) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // shift and count datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            addr_q  <= '0;
            out_bit <= 1'b0;
        end else if (!cs_act) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            out_bit <= 1'b0;
        end else begin
            if (rise && (state == ST_INSTR || state == ST_WDATA)) begin
                rx_sh   <= rx_next;
                bit_cnt <= bit_cnt + 3'd1;
            end
            if (state == ST_INSTR && byte_done) begin
                addr_q <= rx_canon[AW-1:0];
                tx_sh  <= lsb_first ? flip_byte(rd_data) : rd_data;
            end
            if (state == ST_RDATA && fall) begin
                out_bit <= tx_sh[7];
                tx_sh   <= {tx_sh[6:0], 1'b0};
            end
        end
    end

    // outputs
    always_comb begin
        wr_en   = (state == ST_WDATA) && cs_act && byte_done;
        wr_addr = addr_q;
        wr_data = rx_canon;
        rd_addr = (state == ST_INSTR) ? rx_canon[AW-1:0] : addr_q;
        sdio_oe = (state == ST_RDATA) && !three_wire;
        sdio_o  = sdio_oe ? out_bit : 1'b0;
        sdo     = ((state == ST_RDATA) && three_wire) ? out_bit : 1'b0;
    end

    // R9: chip select release always returns the port to idle
    assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (state == ST_IDLE));
    // R9: a new transaction starts with an empty bit count
    assert_fresh_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_act) |-> (bit_cnt == 3'd0));
    // R1: a completed write byte ends the transaction
    assert_single_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (state == ST_DONE));
    // R8: read bits only move on falling serial clock edges
    assert_launch_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDATA && cs_act && !fall) |=> $stable(out_bit));
endmodule

// File: rtl/serreg_port.sv
module serreg_port #(
    parameter int NREGS    = 4,
    parameter int AW       = 5,
    parameter int MIN_HIGH = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               sclk,
    input  logic               sdio_i,
    output logic               sdio_o,
    output logic               sdio_oe,
    output logic               sdo,
    input  logic               io_update,
    output logic [NREGS*8-1:0] regs_o
);
    logic [2:0]    pins_s;
    logic          upd_s;
    logic          cs_act;
    logic          upd_fire;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;

    serreg_sync #(.W(3), .STAGES(2)) u_pin_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d       ({cs_n, sclk, sdio_i}),
        .rst_val (3'b100),
        .q       (pins_s)
    );

    serreg_sync #(.W(1), .STAGES(2)) u_upd_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d       (io_update),
        .rst_val (1'b0),
        .q       (upd_s)
    );

    assign cs_act = !pins_s[2];

    serreg_upd_qual #(.MIN_HIGH(MIN_HIGH)) u_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .upd_s (upd_s),
        .fire  (upd_fire)
    );

    serreg_bank #(.NREGS(NREGS), .AW(AW)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .upd_fire    (upd_fire),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .active_flat (regs_o)
    );

    serreg_fsm #(.AW(AW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_act     (cs_act),
        .sclk_s     (pins_s[1]),
        .sdi_s      (pins_s[0]),
        .lsb_first  (regs_o[0]),
        .three_wire (regs_o[1]),
        .rd_data    (rd_data),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .sdio_o     (sdio_o),
        .sdio_oe    (sdio_oe),
        .sdo        (sdo)
    );

    // R7: the shared line is never driven in 3-wire mode
    assert_no_turn_3w_R7: assert property (@(posedge clk) disable iff (!rst_n)
        regs_o[1] |-> !sdio_oe);
    // R10: outputs are quiet while reset is held
    always_comb begin
        if (!rst_n) begin
            assert_reset_quiet_R10: assert (regs_o == '0 && !sdio_oe && !sdo);
        end
    end
endmodule

// File: tb/serreg_port_tb.sv
module serreg_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 8;
    localparam int NREGS      = 4;

    logic clk = 1'b0;
    logic rst_n, cs_n, sclk, sdio_i, io_update;
    logic sdio_o, sdio_oe, sdo;
    logic [NREGS*8-1:0] regs_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [7:0] shd [NREGS];
    logic [7:0] act [NREGS];

    always #(CLK_PERIOD/2) clk = ~clk;

    serreg_port #(.NREGS(NREGS)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdio_i(sdio_i),
        .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo(sdo),
        .io_update(io_update), .regs_o(regs_o)
    );

    function automatic logic [NREGS*8-1:0] model_flat();
        logic [NREGS*8-1:0] f;
        for (int k = 0; k < NREGS; k++) f[k*8 +: 8] = act[k];
        return f;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // one serial bit: fall, drive, wait, sample, rise, wait
    task automatic bit_cyc(input bit ih, input logic b, output logic smp, output logic oe_smp);
        sclk   = 1'b0;
        sdio_i = b;
        tick(H);
        smp    = act[0][1] ? sdo : sdio_o;
        oe_smp = sdio_oe;
        sclk   = 1'b1;
        tick(H);
        if (!ih) sclk = 1'b0;
    endtask

    // full or truncated transaction; nb = number of bits clocked (16 = complete)
    task automatic xfer(input bit ih, input bit rw, input logic [4:0] a,
                        input logic [7:0] wd, input int nb,
                        output logic [7:0] rd, output int oe_err);
        logic [7:0] ins;
        logic smp, oe_smp;
        bit lsb;
        ins    = {rw, 2'b00, a};
        lsb    = act[0][0];
        rd     = '0;
        oe_err = 0;
        sclk   = ih;
        tick(H);
        cs_n   = 1'b0;
        tick(H);
        for (int i = 0; i < nb; i++) begin
            logic b;
            if (i < 8) b = lsb ? ins[i] : ins[7-i];
            else       b = lsb ? wd[i-8] : wd[15-i];
            bit_cyc(ih, b, smp, oe_smp);
            if (i >= 8 && rw) begin
                if (lsb) rd[i-8]  = smp;
                else     rd[15-i] = smp;
                if (oe_smp !== !act[0][1]) oe_err++;
            end
        end
        cs_n = 1'b1;
        tick(2*H);
        if (nb == 16 && !rw && a < NREGS) shd[a] = wd;
    endtask

    task automatic pulse_upd(input int len);
        io_update = 1'b1;
        tick(len);
        io_update = 1'b0;
        tick(10);
        if (len >= 2) for (int k = 0; k < NREGS; k++) act[k] = shd[k];
    endtask

    initial begin
        logic [7:0] rd;
        int oe_err;
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdio_i = 1'b0; io_update = 1'b0;
        for (int k = 0; k < NREGS; k++) begin shd[k] = '0; act[k] = '0; end
        tick(5);
        chk("R10 regs reset", regs_o, '0);
        chk("R10 oe reset", {sdio_oe, sdo, sdio_o}, 3'b000);
        rst_n = 1'b1;
        tick(4);

        // sweep over read path, bit order and serial clock idle level
        for (int cfg = 0; cfg < 4; cfg++) begin
            for (int ih = 0; ih < 2; ih++) begin
                xfer(ih[0], 1'b0, 5'd0, 8'(cfg), 16, rd, oe_err);
                pulse_upd(4);
                chk("R4 mode reg", regs_o[7:0], 8'(cfg));
                for (int a = 1; a < NREGS; a++) begin
                    logic [7:0] wd;
                    wd = 8'((a*37 + cfg*11 + ih*5 + 8'h5A) & 8'hFF);
                    xfer(ih[0], 1'b0, 5'(a), wd, 16, rd, oe_err);
                    chk("R2 no change before update", regs_o, model_flat());
                end
                pulse_upd(4);
                chk("R3 copy on update", regs_o, model_flat());
                for (int a = 0; a < NREGS; a++) begin
                    xfer(ih[0], 1'b1, 5'(a), 8'h00, 16, rd, oe_err);
                    chk("R1 R5 R8 readback", rd, act[a]);
                    chk("R7 read path enable", oe_err, 0);
                end
                xfer(ih[0], 1'b0, 5'd2, ~act[2], 16, rd, oe_err);
                xfer(ih[0], 1'b1, 5'd2, 8'h00, 16, rd, oe_err);
                chk("R6 read returns active", rd, act[2]);
                pulse_upd(4);
                chk("R6 pending copied", regs_o[23:16], shd[2]);
            end
        end

        // R4: bit order change waits for update
        xfer(1'b0, 1'b0, 5'd0, 8'h00, 16, rd, oe_err);
        xfer(1'b0, 1'b1, 5'd1, 8'h00, 16, rd, oe_err);
        chk("R4 order unchanged before update", rd, act[1]);
        pulse_upd(4);
        xfer(1'b1, 1'b1, 5'd1, 8'h00, 16, rd, oe_err);
        chk("R4 msb order after update", rd, act[1]);
        chk("R7 2-wire oe", oe_err, 0);

        // R3: single-clock pulse ignored, long pulse accepted
        xfer(1'b0, 1'b0, 5'd3, 8'hC3, 16, rd, oe_err);
        pulse_upd(1);
        chk("R3 short pulse ignored", regs_o, model_flat());
        pulse_upd(5);
        chk("R3 long pulse copies", regs_o[31:24], 8'hC3);

        // R6: out-of-range address
        xfer(1'b0, 1'b0, 5'd9, 8'hEE, 16, rd, oe_err);
        pulse_upd(4);
        chk("R6 out-of-range write ignored", regs_o, model_flat());
        xfer(1'b0, 1'b1, 5'd9, 8'h00, 16, rd, oe_err);
        chk("R6 out-of-range read zero", rd, 8'h00);

        // R9: aborts
        xfer(1'b0, 1'b0, 5'd1, 8'h99, 12, rd, oe_err);
        pulse_upd(4);
        chk("R9 aborted write dropped", regs_o, model_flat());
        xfer(1'b1, 1'b1, 5'd3, 8'h00, 3, rd, oe_err);
        xfer(1'b1, 1'b0, 5'd1, 8'h3C, 16, rd, oe_err);
        pulse_upd(4);
        chk("R9 fresh after partial", regs_o[15:8], 8'h3C);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule